// File: doc/BRIEF.md
# Reloading Interval Timer with Byte-Wide Latch

This block is a 16-bit down-counter paired with a 16-bit reload latch. Software reaches both through byte-wide locations on an 8-bit register bus. A clock-enable input `tick` sets the count rate, so the counter moves only in cycles where `tick` is high. A mode bit selects one of two behaviours. In one-shot mode, one interrupt is raised per arming. In continuous mode, the counter reloads itself from the latch after it passes through all-ones.

The timer keeps a single interrupt flag and drives it straight out to an external interrupt controller. That controller can clear the flag with a one-cycle strobe. Software can also clear the flag as a side effect of certain register accesses. The two counter bytes and the two latch bytes have different write side effects. These side effects decide when the latch moves into the counter and when the flag is cleared. A high-then-low read pair of the counter returns a coherent 16-bit value, even while the counter is running.

Top module: `reload_timer`

## Requirements
- R1: After synchronous reset, the latch and the counter both hold 0xFFFF, the flag is low, the mode is one-shot and `rdata` is 0x00.
- R2: Register addresses are 0 = counter low, 1 = counter high, 2 = latch low, 3 = latch high and 4 = control, where control bit 0 is 1 for continuous and 0 for one-shot. Read data appears on `rdata` in the cycle after the `rd_en` edge. Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R3: On each clock edge with `tick` high, the counter decrements by one, wrapping from 0x0000 to 0xFFFF. With `tick` low, it holds its value.
- R4: In continuous mode, a tick while the counter is 0xFFFF loads it from the latch. A latch value L therefore gives a period of L+2 ticks.
- R5: The flag is set on the tick edge at which the counter becomes zero, whether by decrement or by reload. In continuous mode, this happens on every period.
- R6: In one-shot mode, only the first zero after a counter-high write sets the flag. The counter keeps counting down through zero to 0xFFFF and below, and it does not reload.
- R7: A counter-high write does four things. It puts the data byte in the latch high byte. It loads the counter with {data, latch low byte}. It clears the flag. It re-arms one-shot mode. A tick in that same cycle is ignored.
- R8: A counter-low or latch-low write changes only the latch low byte. The count and the flag are unchanged.
- R9: A latch-high write changes the latch high byte and clears the flag. The count is unchanged.
- R10: A counter-low read returns the count low byte and clears the flag. A counter-high read returns the count high byte and leaves the flag alone.
- R11: Reads of the latch-low and latch-high addresses return the latch bytes and have no effect on the flag or the count.
- R12: A counter-low read in the cycle right after a counter-high read returns the low byte as it stood at the counter-high read edge. A counter-low read at any other time returns the live low byte.
- R13: The `flag_clr` strobe clears the flag. If an expiry coincides with any clear, the expiry wins and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable; one decrement per cycle while high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| flag_clr | input | 1 | Clear strobe from the interrupt controller |
| irq_flag | output | 1 | Timer interrupt flag |

## Verification
Every effect of a bus access or a tick is registered once. This covers the counter, the flag, the latch and `rdata`. The result is therefore visible one clock edge after the stimulus, and the bench drives on the falling edge and samples on the next falling edge. In the continuous sweeps, the clear strobe stays high together with `tick`, so the flag is high in a sampled cycle exactly when an expiry happened at the preceding edge. The bench compares it each tick against the arithmetic model: zero is reached at L + m(L+2) ticks. The coherence check ticks during both halves of a read pair, so a live low byte would differ from the captured one.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 2;
    localparam int CNT_W     = BYTE_W * NUM_BYTES;
    localparam int ADDR_W    = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t ADR_CNT_LO = addr_t'(0);
    localparam addr_t ADR_CNT_HI = addr_t'(1);
    localparam addr_t ADR_LAT_LO = addr_t'(2);
    localparam addr_t ADR_LAT_HI = addr_t'(3);
    localparam addr_t ADR_CTRL   = addr_t'(4);

    localparam cnt_t CNT_ALL_ONES = '1;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_FREERUN = 1'b1
    } mode_e;

    // Decoded bus side effects
    typedef struct packed {
        logic load;    // counter-high write: transfer latch to counter
        logic wr_clr;  // write that clears the flag
        logic rd_lo;   // counter-low read
        logic rd_hi;   // counter-high read
    } ctl_s;

    function automatic byte_t lo_byte(cnt_t v);
        return v[BYTE_W-1:0];
    endfunction

    function automatic byte_t hi_byte(cnt_t v);
        return v[CNT_W-1 -: BYTE_W];
    endfunction
endpackage

// File: rtl/rtm_regs.sv
module rtm_regs
    import rtm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  rd_en,
    input  addr_t addr,
    input  byte_t wdata,
    output cnt_t  latch_q,
    output mode_e mode_q,
    output cnt_t  load_val,
    output ctl_s  ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= CNT_ALL_ONES;
            mode_q  <= MODE_ONESHOT;
        end else if (wr_en) begin
            case (addr)
                ADR_CNT_LO, ADR_LAT_LO: latch_q[BYTE_W-1:0]       <= wdata;
                ADR_CNT_HI, ADR_LAT_HI: latch_q[CNT_W-1 -: BYTE_W] <= wdata;
                ADR_CTRL:               mode_q <= mode_e'(wdata[0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        ctl.load   = wr_en && (addr == ADR_CNT_HI);
        ctl.wr_clr = wr_en && ((addr == ADR_CNT_HI) || (addr == ADR_LAT_HI));
        ctl.rd_lo  = rd_en && (addr == ADR_CNT_LO);
        ctl.rd_hi  = rd_en && (addr == ADR_CNT_HI);
        load_val   = {wdata, lo_byte(latch_q)};
    end
endmodule

// File: rtl/rtm_count.sv
module rtm_count
    import rtm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  mode_e mode,
    input  logic  load,
    input  cnt_t  load_val,
    input  cnt_t  latch,
    input  logic  clr,
    output cnt_t  cnt_q,
    output logic  flag_q
);
    cnt_t nxt;
    logic expire;
    logic armed_q;

    always_comb begin
        if (mode == MODE_FREERUN && cnt_q == CNT_ALL_ONES)
            nxt = latch;
        else
            nxt = cnt_q - cnt_t'(1);
        expire = tick && !load && (nxt == '0) &&
                 (mode == MODE_FREERUN || armed_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= CNT_ALL_ONES;
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (load)
                cnt_q <= load_val;
            else if (tick)
                cnt_q <= nxt;

            if (load)
                armed_q <= 1'b1;
            else if (expire)
                armed_q <= 1'b0;

            // an expiry outranks any clear in the same cycle
            if (expire)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rtm_rdback.sv
module rtm_rdback
    import rtm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  addr_t addr,
    input  logic  rd_hi,
    input  cnt_t  cnt,
    input  cnt_t  latch,
    input  mode_e mode,
    output byte_t rdata
);
    byte_t snap_q;
    logic  snap_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata      <= '0;
            snap_q     <= '0;
            snap_vld_q <= 1'b0;
        end else begin
            snap_vld_q <= rd_hi;
            if (rd_hi)
                snap_q <= lo_byte(cnt);
            if (rd_en) begin
                case (addr)
                    ADR_CNT_LO: rdata <= snap_vld_q ? snap_q : lo_byte(cnt);
                    ADR_CNT_HI: rdata <= hi_byte(cnt);
                    ADR_LAT_LO: rdata <= lo_byte(latch);
                    ADR_LAT_HI: rdata <= hi_byte(latch);
                    ADR_CTRL:   rdata <= {{(BYTE_W-1){1'b0}}, mode};
                    default:    rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              flag_clr,
    output logic              irq_flag
);
    cnt_t  latch_q;
    cnt_t  cnt_q;
    cnt_t  load_val;
    mode_e mode_q;
    ctl_s  ctl;
    logic  clr_any;

    assign clr_any = ctl.wr_clr || ctl.rd_lo || flag_clr;

    rtm_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .latch_q  (latch_q),
        .mode_q   (mode_q),
        .load_val (load_val),
        .ctl      (ctl)
    );

    rtm_count u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (mode_q),
        .load     (ctl.load),
        .load_val (load_val),
        .latch    (latch_q),
        .clr      (clr_any),
        .cnt_q    (cnt_q),
        .flag_q   (irq_flag)
    );

    rtm_rdback u_rdback (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .addr  (addr),
        .rd_hi (ctl.rd_hi),
        .cnt   (cnt_q),
        .latch (latch_q),
        .mode  (mode_q),
        .rdata (rdata)
    );
endmodule

// File: rtl/rtm_checker.sv
module rtm_checker
    import rtm_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  tick,
    input logic  wr_en,
    input logic  rd_en,
    input addr_t addr,
    input logic  flag_clr,
    input logic  irq_flag,
    input cnt_t  cnt_q,
    input cnt_t  latch_q,
    input mode_e mode_q
);
    logic hi_wr;
    assign hi_wr = wr_en && (addr == ADR_CNT_HI);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hi_wr) |=> $stable(cnt_q));

    assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !hi_wr && mode_q == MODE_FREERUN && cnt_q == CNT_ALL_ONES)
        |=> (cnt_q == $past(latch_q)));

    assert_rise_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $past(tick));

    assert_load_clears_R7: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> !irq_flag);

    assert_low_write_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tick && (addr == ADR_CNT_LO || addr == ADR_LAT_LO)) |=> $stable(cnt_q));

    assert_rdlo_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADR_CNT_LO && !tick) |=> !irq_flag);

    assert_strobe_clears_R13: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !tick) |=> !irq_flag);
endmodule

bind reload_timer rtm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .flag_clr (flag_clr),
    .irq_flag (irq_flag),
    .cnt_q    (cnt_q),
    .latch_q  (latch_q),
    .mode_q   (mode_q)
);

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       wr_en;
    logic       rd_en;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       flag_clr;
    logic       irq_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_timer u_reload_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .flag_clr (flag_clr),
        .irq_flag (irq_flag)
    );

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        rd_en = 1'b1; addr = a;
        step();
        rd_en = 1'b0;
        d = int'(rdata);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) step();
        tick = 1'b0;
    endtask

    // one-shot flag set: load 2 and run two ticks
    task automatic set_flag();
        wr(3'd0, 8'h02);
        wr(3'd1, 8'h00);
        ticks(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int v;
        int hi;
        int lo;
        int one_lat[5] = '{1, 2, 3, 7, 258};
        int cont_lat[4] = '{0, 1, 2, 5};
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        addr = '0; wdata = '0; flag_clr = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1: reset state
        check("R1 rdata", int'(rdata), 0);
        check("R1 flag", int'(irq_flag), 0);
        rd(3'd2, v); check("R1 latch lo", v, 8'hFF);
        rd(3'd3, v); check("R1 latch hi", v, 8'hFF);
        rd(3'd4, v); check("R1 mode", v, 0);
        rd(3'd1, v); check("R1 count hi", v, 8'hFF);
        rd(3'd0, v); check("R1 count lo", v, 8'hFF);

        // R2: unused addresses
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 8'hFF);
            rd(3'(a), v); check("R2 unused read", v, 0);
        end
        rd(3'd4, v); check("R2 ctrl untouched", v, 0);
        rd(3'd2, v); check("R2 latch untouched", v, 8'hFF);

        // R6/R5/R3: one-shot sweep
        for (int i = 0; i < 5; i++) begin
            int L = one_lat[i];
            wr(3'd2, 8'(L));
            wr(3'd1, 8'(L >> 8));
            check("R7 flag cleared by load", int'(irq_flag), 0);
            for (int k = 1; k <= L + 3; k++) begin
                ticks(1);
                check("R6 one-shot flag", int'(irq_flag), (k >= L) ? 1 : 0);
            end
            rd(3'd1, hi); rd(3'd0, lo);
            check("R3 count after wrap", (hi << 8) | lo, 16'hFFFD);
            check("R10 lo read clears", int'(irq_flag), 0);
            ticks(5);
            check("R6 no second flag", int'(irq_flag), 0);
            rd(3'd1, hi); rd(3'd0, lo);
            check("R6 keeps counting", (hi << 8) | lo, 16'hFFF8);
        end

        // R4/R5/R13: continuous sweep, clear strobe held with tick
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R2 ctrl continuous", v, 1);
        for (int i = 0; i < 4; i++) begin
            int L = cont_lat[i];
            wr(3'd2, 8'(L));
            wr(3'd1, 8'h00);
            flag_clr = 1'b1;
            for (int k = 1; k <= 3 * (L + 2); k++) begin
                ticks(1);
                check("R4 R5 R13 continuous expiry", int'(irq_flag),
                      (k >= L && ((k - L) % (L + 2)) == 0) ? 1 : 0);
            end
            flag_clr = 1'b0;
            rd(3'd1, hi); rd(3'd0, lo);
            check("R4 count after whole periods", (hi << 8) | lo, L);
        end
        wr(3'd4, 8'h00);

        // R7: tick ignored in the load cycle
        wr(3'd2, 8'h34);
        tick = 1'b1;
        wr(3'd1, 8'h12);
        tick = 1'b0;
        rd(3'd1, hi); rd(3'd0, lo);
        check("R7 load value", (hi << 8) | lo, 16'h1234);
        rd(3'd3, v); check("R7 latch hi", v, 8'h12);

        // R8/R10/R11: side effects of accesses
        set_flag();
        check("R5 flag set at zero", int'(irq_flag), 1);
        wr(3'd0, 8'h5A);
        check("R8 flag kept", int'(irq_flag), 1);
        rd(3'd2, v); check("R8 latch lo via count-lo write", v, 8'h5A);
        wr(3'd2, 8'h6B);
        check("R8 flag kept latch-lo", int'(irq_flag), 1);
        rd(3'd2, v); check("R11 latch lo", v, 8'h6B);
        rd(3'd3, v); check("R11 latch hi", v, 8'h00);
        check("R11 flag kept", int'(irq_flag), 1);
        rd(3'd1, v); check("R10 count hi", v, 0);
        check("R10 hi read keeps flag", int'(irq_flag), 1);
        rd(3'd0, v); check("R8 count unchanged", v, 0);
        check("R10 lo read clears flag", int'(irq_flag), 0);

        // R9: latch-high write
        set_flag();
        wr(3'd3, 8'hAB);
        check("R9 flag cleared", int'(irq_flag), 0);
        rd(3'd1, v); check("R9 count unchanged", v, 0);
        rd(3'd3, v); check("R9 latch hi", v, 8'hAB);

        // R13: clear strobe
        set_flag();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        check("R13 strobe clears", int'(irq_flag), 0);

        // R12: coherent pair while ticking
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h01);
        tick = 1'b1;
        rd(3'd1, hi);
        rd(3'd0, lo);
        tick = 1'b0;
        check("R12 coherent hi", hi, 8'h01);
        check("R12 coherent lo", lo, 8'h00);
        step();
        rd(3'd0, lo);
        check("R12 live lo", lo, 8'hFE);

        report();
    end
endmodule